// File: doc/BRIEF.md
# Configurable ADC output serializer

This block turns parallel converter samples into serial words on eight data lanes. It also drives a frame clock that marks each word boundary and a bit clock at half the bit rate, so that each bit clock edge carries one bit (double data rate). The block runs on a clock at twice the bit rate, so one bit lasts two clock cycles and one bit-clock period lasts four cycles. This gives the 90-degree resolution that the bit-clock phase control needs. The word length can be 8, 12, 14 or 16 bits. The sample sits left-justified in the word, and the unused low positions of the longer words are filled with zeros. Control inputs select the bit order and the number format, shift the data and frame clock one bit earlier or later, and set the bit-clock phase.

The channel mode decides which input sample drives which lane. One channel can be spread across all eight lanes, two channels can take four lanes each, or four channels can take one lane pair each. A sample-valid strobe captures one sample per input slot into holding registers. Each lane copies its holding register into a frame register at the start of a word, so a new sample never changes a word that is already being sent. The word length and the channel mode are captured only while the power-down input is high. Raising power-down is therefore the way to change them. While power-down is high, every output stays low and the word timing restarts.

Top module: `adc_lane_serializer`

## Requirements
- R1: The word length is set by `wl_code`. Code 3'b000 gives 12 bits, 3'b001 gives 14, 3'b010 gives 16 and 3'b011 gives 8. Any code with bit 2 set is reserved and gives 12. One word of W bits lasts 2*W clock cycles.
- R2: Let s be the sample after formatting, with SMP_W = 13 bits. A 16-bit word is {s, 3'b000}, a 14-bit word is {s, 1'b0}, a 12-bit word is s[12:1] and an 8-bit word is s[12:5].
- R3: The 8-bit length is granted only in single-channel mode. Code 3'b011 in dual or quad mode gives 12 bits.
- R4: With `msb_first` low, word bit 0 is sent first. With `msb_first` high, bit W-1 is sent first. Each bit is held on its lane for two clock cycles.
- R5: With `twos_fmt` high, bit 12 of the sample is inverted before the word is built. With `twos_fmt` low, the sample is used unchanged.
- R6: Sample slot s of channel c is taken from `chan_smp[(c*8+s)*13 +: 13]`. For lane l, `ch_code` 2'b00 uses channel 0, slot l. Code 2'b01 uses channel l/4, slot l%4. Codes 2'b10 and 2'b11 use channel l/2, slot l%2. No other slot has any effect.
- R7: The frame clock is high during bits 0 to W/2-1 of each word and low during the rest. It changes in the same cycle as the data.
- R8: With `adv_bit` high and `dly_bit` low, the data and the frame clock run two cycles (one bit) ahead of the unshifted timing, relative to the bit clock. With `dly_bit` high and `adv_bit` low, they run two cycles behind. With both high, or both low, there is no shift.
- R9: Output tick j counts from 0 at the first cycle after power-down is released. The bit clock has a period of four cycles. It is high in output tick j when (j - p) mod 4 is 0 or 1, where p is `bclk_phase`. Each step of p is one cycle, which is 90 degrees.
- R10: The word length and the channel mode are captured only while `pwr_dn` is high. Changes to `wl_code` or `ch_code` while running have no effect.
- R11: While `pwr_dn` is high, all lanes, the frame clock and the bit clock are low. The first output cycle after release is tick 0 of a new word.
- R12: After reset, all outputs are low, the holding registers are zero, and the configuration is 12 bits in single-channel mode until the first power-down.
- R13: A sample captured by `smp_vld` appears from the next word start onward. The word in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: idles the outputs and captures the word length and channel mode |
| wl_code | input | 3 | Word-length code |
| ch_code | input | 2 | Channel-mode code |
| msb_first | input | 1 | Send the MSB first when high |
| twos_fmt | input | 1 | Two's complement output when high |
| adv_bit | input | 1 | Move the data and frame clock one bit earlier |
| dly_bit | input | 1 | Move the data and frame clock one bit later |
| bclk_phase | input | 2 | Bit-clock phase in 90-degree steps |
| smp_vld | input | 1 | Capture all sample slots into the holding registers |
| chan_smp | input | 416 | Sample slots: 4 channels by 8 slots of 13 bits |
| lane_out | output | 8 | Serial data lanes |
| fclk_out | output | 1 | Frame clock |
| bclk_out | output | 1 | Bit clock |

## Verification
A wrong value in the tick counter or in the captured word length shows at once on the frame clock. The frame clock's high time or its period is wrong within one word, that is 16 to 32 cycles. A wrong lane mapping, format or bit-order choice, or a bad frame register, shows as a wrong reconstructed lane word within two words of the release of power-down. The checks start after the first two words, so that the frame registers have been loaded under every shift setting. Captured configuration that leaks from the live code inputs is exposed because the bench changes those codes right after each release.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

   localparam int MAX_WORD = 16;
   localparam int WLEN_W   = 5;

   typedef enum logic [1:0] {
      CH_SINGLE = 2'd0,
      CH_DUAL   = 2'd1,
      CH_QUAD   = 2'd2
   } ch_mode_e;

   function automatic ch_mode_e decode_ch(input logic [1:0] code);
      case (code)
         2'b00:   return CH_SINGLE;
         2'b01:   return CH_DUAL;
         default: return CH_QUAD;
      endcase
   endfunction

   function automatic logic [WLEN_W-1:0] decode_wlen(input logic [2:0] code,
                                                     input ch_mode_e   ch);
      case (code)
         3'b001:  return WLEN_W'(14);
         3'b010:  return WLEN_W'(16);
         3'b011:  return (ch == CH_SINGLE) ? WLEN_W'(8) : WLEN_W'(12);
         default: return WLEN_W'(12);
      endcase
   endfunction

endpackage

// File: rtl/ser_cfg_latch.sv
module ser_cfg_latch
   import adc_ser_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic [2:0]        wl_code,
   input  logic [1:0]        ch_code,
   output logic [WLEN_W-1:0] wlen,
   output ch_mode_e          ch_mode
);

   ch_mode_e ch_next;

   always_comb ch_next = decode_ch(ch_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wlen    <= WLEN_W'(12);
         ch_mode <= CH_SINGLE;
      end else if (pwr_dn) begin
         wlen    <= decode_wlen(wl_code, ch_next);
         ch_mode <= ch_next;
      end
   end

   // R10: configuration frozen while running
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_dn && $past(!pwr_dn)) |-> ($stable(wlen) && $stable(ch_mode)));

   // R3: narrow words only with one channel
   p_narrow_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wlen == WLEN_W'(8)) |-> (ch_mode == CH_SINGLE));

endmodule

// File: rtl/ser_timing.sv
module ser_timing
   import adc_ser_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_dn,
   input  logic [WLEN_W-1:0]   wlen,
   input  logic                adv_bit,
   input  logic                dly_bit,
   input  logic [1:0]          bclk_phase,
   output logic                load,
   output logic [WLEN_W-1:0]   bidx,
   output logic                fclk_q,
   output logic                bclk_q
);

   localparam int TK_W = WLEN_W + 1;

   logic [TK_W-1:0] tk;
   logic [TK_W-1:0] ft;
   logic [TK_W-1:0] td;
   logic [TK_W:0]   sum;
   logic [1:0]      ph_q;
   logic            fclk_nx;
   logic            run_q;

   always_comb begin
      ft  = {wlen, 1'b0};
      sum = {1'b0, tk};
      if (adv_bit && !dly_bit)
         sum = sum + (TK_W+1)'(2);
      else if (dly_bit && !adv_bit)
         sum = sum + {1'b0, ft} - (TK_W+1)'(2);
      if (sum >= {1'b0, ft})
         td = TK_W'(sum - {1'b0, ft});
      else
         td = sum[TK_W-1:0];
      bidx    = td[TK_W-1:1];
      load    = (td == '0) && !pwr_dn;
      fclk_nx = (bidx < (wlen >> 1));
      ph_q    = tk[1:0] - bclk_phase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tk     <= '0;
         fclk_q <= 1'b0;
         bclk_q <= 1'b0;
         run_q  <= 1'b0;
      end else if (pwr_dn) begin
         tk     <= '0;
         fclk_q <= 1'b0;
         bclk_q <= 1'b0;
         run_q  <= 1'b0;
      end else begin
         tk     <= (tk == ft - TK_W'(1)) ? '0 : tk + TK_W'(1);
         fclk_q <= fclk_nx;
         bclk_q <= ~ph_q[1];
         run_q  <= 1'b1;
      end
   end

   // R1: tick counter stays inside one word
   p_tick_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tk < ft);

   // R9: bit clock period of four cycles
   p_bclk_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && $past(run_q, 2)) |-> (bclk_q != $past(bclk_q, 2)));

   // R11: idle frame clock after power-down
   p_fclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!fclk_q && !bclk_q));

endmodule

// File: rtl/ser_lane.sv
module ser_lane
   import adc_ser_pkg::*;
#(
   parameter int SMP_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              smp_vld,
   input  logic [SMP_W-1:0]  smp_in,
   input  logic              twos_fmt,
   input  logic              msb_first,
   input  logic [WLEN_W-1:0] wlen,
   input  logic              load,
   input  logic [WLEN_W-1:0] bidx,
   output logic              lane_q
);

   localparam int PAD   = MAX_WORD - SMP_W;
   localparam int POS_W = $clog2(MAX_WORD);

   logic [SMP_W-1:0]    hold_q;
   logic [SMP_W-1:0]    fmt_s;
   logic [MAX_WORD-1:0] w16;
   logic [MAX_WORD-1:0] word_now;
   logic [MAX_WORD-1:0] frame_q;
   logic [MAX_WORD-1:0] src;
   logic [WLEN_W-1:0]   shamt;
   logic [WLEN_W-1:0]   pos;

   always_comb begin
      fmt_s = hold_q;
      if (twos_fmt)
         fmt_s[SMP_W-1] = ~hold_q[SMP_W-1];
      w16      = MAX_WORD'(fmt_s) << PAD;
      shamt    = WLEN_W'(MAX_WORD) - wlen;
      word_now = w16 >> shamt;
      src      = load ? word_now : frame_q;
      pos      = msb_first ? (wlen - WLEN_W'(1) - bidx) : bidx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (smp_vld)
         hold_q <= smp_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         lane_q  <= 1'b0;
      end else if (pwr_dn) begin
         frame_q <= '0;
         lane_q  <= 1'b0;
      end else begin
         if (load)
            frame_q <= word_now;
         lane_q <= src[pos[POS_W-1:0]];
      end
   end

   // R11: lane idle after power-down
   p_lane_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !lane_q);

   generate
      if (PAD > 0) begin : g_pad_chk
         // R2: low positions of a full-length word are zero
         p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wlen == WLEN_W'(MAX_WORD)) |-> (frame_q[PAD-1:0] == '0));
      end
   endgenerate

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
   import adc_ser_pkg::*;
#(
   parameter int LANES = 8,
   parameter int SMP_W = 13
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pwr_dn,
   input  logic [2:0]                   wl_code,
   input  logic [1:0]                   ch_code,
   input  logic                         msb_first,
   input  logic                         twos_fmt,
   input  logic                         adv_bit,
   input  logic                         dly_bit,
   input  logic [1:0]                   bclk_phase,
   input  logic                         smp_vld,
   input  logic [4*LANES*SMP_W-1:0]     chan_smp,
   output logic [LANES-1:0]             lane_out,
   output logic                         fclk_out,
   output logic                         bclk_out
);

   localparam int NCH     = 4;
   localparam int DUAL_SL = LANES / 2;
   localparam int QUAD_SL = LANES / NCH;

   generate
      if (LANES % NCH != 0) begin : g_bad_lanes
         $error("LANES must be a multiple of four");
      end
      if (SMP_W < 8 || SMP_W > MAX_WORD) begin : g_bad_width
         $error("SMP_W must lie between 8 and 16");
      end
   endgenerate

   logic [WLEN_W-1:0] wlen;
   ch_mode_e          ch_mode;
   logic              load;
   logic [WLEN_W-1:0] bidx;

   ser_cfg_latch u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_dn  (pwr_dn),
      .wl_code (wl_code),
      .ch_code (ch_code),
      .wlen    (wlen),
      .ch_mode (ch_mode)
   );

   ser_timing u_tim (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_dn     (pwr_dn),
      .wlen       (wlen),
      .adv_bit    (adv_bit),
      .dly_bit    (dly_bit),
      .bclk_phase (bclk_phase),
      .load       (load),
      .bidx       (bidx),
      .fclk_q     (fclk_out),
      .bclk_q     (bclk_out)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int C_DUAL = l / DUAL_SL;
         localparam int S_DUAL = l % DUAL_SL;
         localparam int C_QUAD = l / QUAD_SL;
         localparam int S_QUAD = l % QUAD_SL;
         localparam int B_ONE  = l * SMP_W;
         localparam int B_DUAL = (C_DUAL * LANES + S_DUAL) * SMP_W;
         localparam int B_QUAD = (C_QUAD * LANES + S_QUAD) * SMP_W;

         logic [SMP_W-1:0] slot;

         always_comb begin
            case (ch_mode)
               CH_SINGLE: slot = chan_smp[B_ONE  +: SMP_W];
               CH_DUAL:   slot = chan_smp[B_DUAL +: SMP_W];
               default:   slot = chan_smp[B_QUAD +: SMP_W];
            endcase
         end

         ser_lane #(.SMP_W(SMP_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_dn    (pwr_dn),
            .smp_vld   (smp_vld),
            .smp_in    (slot),
            .twos_fmt  (twos_fmt),
            .msb_first (msb_first),
            .wlen      (wlen),
            .load      (load),
            .bidx      (bidx),
            .lane_q    (lane_out[l])
         );
      end
   endgenerate

   // R11: all outputs idle during power-down
   p_out_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (lane_out == '0 && !fclk_out && !bclk_out));

endmodule

// File: tb/adc_lane_serializer_test.sv
module adc_lane_serializer_test;

   localparam int CLK_PERIOD = 10;
   localparam int LN = 8;
   localparam int SW = 13;
   localparam int NV = 10;

   // {wl[18:16], ch[15:14], msb, fmt, adv, dly, ph[9:8], seed[7:0]}
   localparam logic [18:0] VECS [NV] = '{
      {3'b000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1},
      {3'b001, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'd2},
      {3'b010, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 8'd3},
      {3'b011, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'd4},
      {3'b011, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd5},
      {3'b010, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'd6},
      {3'b001, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 8'd7},
      {3'b101, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 8'd8},
      {3'b011, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 8'd9},
      {3'b000, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd10}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic [2:0] wl_code = 3'b010;
   logic [1:0] ch_code = 2'b00;
   logic msb_first = 1'b0, twos_fmt = 1'b0, adv_bit = 1'b0, dly_bit = 1'b0;
   logic [1:0] bclk_phase = 2'd0;
   logic smp_vld = 1'b0;
   logic [4*LN*SW-1:0] chan_smp = '0;
   logic [LN-1:0] lane_out;
   logic fclk_out, bclk_out;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;
   int g_w, g_ch, g_msb, g_fmt, g_adv, g_dly, g_ph;

   adc_lane_serializer uut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .wl_code(wl_code),
      .ch_code(ch_code), .msb_first(msb_first), .twos_fmt(twos_fmt),
      .adv_bit(adv_bit), .dly_bit(dly_bit), .bclk_phase(bclk_phase),
      .smp_vld(smp_vld), .chan_smp(chan_smp), .lane_out(lane_out),
      .fclk_out(fclk_out), .bclk_out(bclk_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
         fails++;
         checks++;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic int gen(int seed, int c, int s);
      return (seed * 1237 + c * 389 + s * 97 + 55) & 16'h1FFF;
   endfunction

   task automatic load_slots(input int seed);
      for (int c = 0; c < 4; c++)
         for (int s = 0; s < LN; s++)
            chan_smp[(c*LN+s)*SW +: SW] = SW'(gen(seed, c, s));
   endtask

   function automatic int exp_w(int wl, int ch);
      case (wl)
         1: return 14;
         2: return 16;
         3: return (ch == 0) ? 8 : 12;
         default: return 12;
      endcase
   endfunction

   function automatic int data_tick(int j);
      int ft = 2 * g_w;
      int sh = 0;
      if (g_adv == 1 && g_dly == 0) sh = 2;
      if (g_dly == 1 && g_adv == 0) sh = -2;
      return (j + ft + sh) % ft;
   endfunction

   function automatic int lane_sample(int seed, int l);
      if (g_ch == 0) return gen(seed, 0, l);
      if (g_ch == 1) return gen(seed, l / 4, l % 4);
      return gen(seed, l / 2, l % 2);
   endfunction

   function automatic int exp_lane(int seed, int l, int j);
      int b = data_tick(j) / 2;
      int ss = lane_sample(seed, l);
      int w16, word, pos;
      if (g_fmt == 1) ss = ss ^ 4096;
      w16  = (ss << 3) & 16'hFFFF;
      word = w16 >> (16 - g_w);
      pos  = (g_msb == 1) ? (g_w - 1 - b) : b;
      return (word >> pos) & 1;
   endfunction

   function automatic int exp_fclk(int j);
      return ((data_tick(j) / 2) < (g_w / 2)) ? 1 : 0;
   endfunction

   function automatic int exp_bclk(int j);
      return (((j - g_ph + 4) % 4) < 2) ? 1 : 0;
   endfunction

   task automatic run_vec(input logic [18:0] v);
      int lerr [LN];
      int fe = 0, be = 0, fh = 0, seed;
      seed = int'(v[7:0]);
      @(negedge clk);
      wl_code = v[18:16]; ch_code = v[15:14];
      msb_first = v[13]; twos_fmt = v[12]; adv_bit = v[11]; dly_bit = v[10];
      bclk_phase = v[9:8];
      load_slots(seed);
      smp_vld = 1'b1; pwr_dn = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      // R11: idle during power-down
      check(lane_out == '0 && !fclk_out && !bclk_out, "R11 idle outputs",
            int'({lane_out, fclk_out, bclk_out}), 0);
      g_w = exp_w(int'(v[18:16]), int'(v[15:14]));
      g_ch = (v[15:14] == 2'b00) ? 0 : (v[15:14] == 2'b01) ? 1 : 2;
      g_msb = int'(v[13]); g_fmt = int'(v[12]); g_adv = int'(v[11]);
      g_dly = int'(v[10]); g_ph = int'(v[9:8]);
      pwr_dn = 1'b0; smp_vld = 1'b0;
      // R10: live code changes and R6 slot changes without strobe are ignored
      wl_code = v[18:16] ^ 3'b011;
      ch_code = v[15:14] ^ 2'b01;
      load_slots(seed + 100);
      for (int l = 0; l < LN; l++) lerr[l] = 0;
      for (int j = 0; j < 6 * g_w; j++) begin
         @(posedge clk); @(negedge clk);
         if (j >= 2 * g_w) begin
            for (int l = 0; l < LN; l++)
               if (int'(lane_out[l]) != exp_lane(seed, l, j)) lerr[l]++;
            if (int'(fclk_out) != exp_fclk(j)) fe++;
            if (int'(bclk_out) != exp_bclk(j)) be++;
            if (fclk_out) fh++;
         end
      end
      for (int l = 0; l < LN; l++)
         check(lerr[l] == 0, $sformatf("R2 R4 R5 R6 lane %0d bit errors", l), lerr[l], 0);
      check(fe == 0, "R7 R8 frame clock errors", fe, 0);
      check(be == 0, "R9 bit clock errors", be, 0);
      check(fh == 2 * g_w, "R1 R3 R10 frame high cycles", fh, 2 * g_w);
   endtask

   initial begin
      int zl = 0, fh = 0, ea = 0, eb = 0;
      load_slots(99);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      check(lane_out == '0 && !fclk_out && !bclk_out, "R12 outputs in reset",
            int'({lane_out, fclk_out, bclk_out}), 0);
      rst_n = 1'b1;
      g_w = 12; g_ch = 0; g_msb = 0; g_fmt = 0; g_adv = 0; g_dly = 0; g_ph = 0;
      for (int j = 0; j < 48; j++) begin
         @(posedge clk); @(negedge clk);
         if (lane_out != '0) zl++;
         if (fclk_out) fh++;
      end
      check(zl == 0, "R12 lanes from cleared holding registers", zl, 0);
      check(fh == 24, "R12 default 12-bit frame high cycles", fh, 24);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R13: new sample mid-word waits for the next word
      @(negedge clk);
      wl_code = 3'b010; ch_code = 2'b00; msb_first = 1'b0; twos_fmt = 1'b0;
      adv_bit = 1'b0; dly_bit = 1'b0; bclk_phase = 2'd0;
      load_slots(20); smp_vld = 1'b1; pwr_dn = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      pwr_dn = 1'b0; smp_vld = 1'b0;
      g_w = 16; g_ch = 0; g_msb = 0; g_fmt = 0; g_adv = 0; g_dly = 0; g_ph = 0;
      for (int j = 0; j < 8 * 16; j++) begin
         @(posedge clk); @(negedge clk);
         for (int l = 0; l < LN; l++) begin
            if (j >= 64 && j < 96 && int'(lane_out[l]) != exp_lane(20, l, j)) ea++;
            if (j >= 96 && int'(lane_out[l]) != exp_lane(21, l, j)) eb++;
         end
         if (j == 70) begin load_slots(21); smp_vld = 1'b1; end
         if (j == 71) smp_vld = 1'b0;
      end
      check(ea == 0, "R13 word in progress keeps old sample", ea, 0);
      check(eb == 0, "R13 next word carries new sample", eb, 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule